// File: doc/BRIEF.md
# Register Dependency Tracking Scoreboard

This block keeps track of register writes that are still outstanding in an in-order pipeline. Every architectural register of the integer, floating-point and miscellaneous classes owns a short queue. The queue holds the sequence numbers of the instructions that will write that register, oldest first. When an instruction issues, its producer entry is appended for each destination register, one destination per cycle. When it retires or is squashed, the entry is removed, either from the head of the queue or by searching for it. A separate marking port records that a producer has executed and the cycle in which its result becomes valid.

A combinational query port takes a register class, an index, a requester sequence number and the current cycle stamp. It answers three questions: may the requester read the register file, may it write the register, and is there an older producer whose result can be forwarded now. Updates presented in one cycle are applied to a queue in a fixed order: head removal, then search removal, then marking, then append. Each error flag describes the operation presented in the same cycle.

Top module: `dep_scoreboard`

## Requirements
- R1: Class code 0 selects integer, 1 floating-point and 2 miscellaneous registers. Each register of each class has its own queue, so an operation on one class never affects the same index in another class. Class code 3 and indices beyond the size of a class name no register: a query on them returns read and write allowed and no forwarding source.
- R2: An append places the new sequence number at the tail, so the queue keeps the order of the appends, and the head is always the oldest outstanding producer.
- R3: Index 0 of the integer class is a hardwired zero register. Append, search removal, head removal and marking aimed at it are ignored, raise no error flag, and leave its queue empty.
- R4: `q_can_read` is 1 when the queue is empty, or when the requester sequence number is less than or equal to the head sequence number. Otherwise it is 0.
- R5: `q_can_write` follows the same rule as R4.
- R6: The forwarding candidate is found by walking from the head and taking the last entry whose sequence number is strictly below the requester's. If the head is not below the requester, there is no candidate.
- R7: `q_fwd_hit` is 1, with `q_fwd_seq` equal to the candidate, only when the candidate is marked executed and its result stamp is strictly below `now_time`. Otherwise `q_fwd_hit` is 0 and `q_fwd_seq` is 0.
- R8: A search removal deletes the matching entry and closes the gap in the same cycle, keeping the age order. If no entry matches, `rm_miss_o` is 1 in that cycle and the queue is unchanged.
- R9: A head removal deletes the head only when the head matches the given sequence number. On a mismatch or an empty queue, `rf_bad_o` is 1 in that cycle and the queue is unchanged.
- R10: An append to a queue holding DEPTH entries (default 4) sets `ins_full_o` in that cycle and leaves the queue unchanged.
- R11: A marking operation sets the executed flag of the matching entry and stores `ex_time` as its result stamp. A fresh append starts unexecuted.
- R12: After reset every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Append request |
| ins_class | input | 2 | Register class of the append |
| ins_idx | input | IDX_W | Register index of the append |
| ins_seq | input | SEQ_W | Producer sequence number to append |
| ins_full_o | output | 1 | Append refused because the queue is full |
| rm_valid | input | 1 | Search-removal request |
| rm_class | input | 2 | Register class of the search removal |
| rm_idx | input | IDX_W | Register index of the search removal |
| rm_seq | input | SEQ_W | Sequence number to delete |
| rm_miss_o | output | 1 | Search removal found no matching entry |
| rf_valid | input | 1 | Head-removal request |
| rf_class | input | 2 | Register class of the head removal |
| rf_idx | input | IDX_W | Register index of the head removal |
| rf_seq | input | SEQ_W | Sequence number expected at the head |
| rf_bad_o | output | 1 | Head removal refused (empty queue or mismatch) |
| ex_valid | input | 1 | Executed-marking request |
| ex_class | input | 2 | Register class of the marking |
| ex_idx | input | IDX_W | Register index of the marking |
| ex_seq | input | SEQ_W | Producer to mark as executed |
| ex_time | input | TIME_W | Cycle stamp at which the result becomes valid |
| now_time | input | TIME_W | Current cycle stamp for forwarding checks |
| q_class | input | 2 | Query register class |
| q_idx | input | IDX_W | Query register index |
| q_seq | input | SEQ_W | Requester sequence number |
| q_can_read | output | 1 | Register file may be read |
| q_can_write | output | 1 | Register may be written |
| q_fwd_hit | output | 1 | A forwarding source is available |
| q_fwd_seq | output | SEQ_W | Sequence number of the forwarding source |

## Verification
The bench goes after the boundary of each comparison. It checks a requester equal to the head, which must be allowed to read; a design that used a strict compare would stall that instruction forever. It checks a result stamp equal to `now_time`, which must be refused; an inclusive compare would forward data one cycle too early. It deletes an entry from the middle of a full queue and then asks for a forwarding source: a design that left a hole, or shifted the wrong slots, would return the deleted producer or skip the real one. It appends to a full queue, removes a head that does not match, removes from an empty queue, and aims every operation at the integer zero register. A design that corrupted a queue on a refused operation, or that tracked the zero register, would then give wrong answers to the later queries.

// File: rtl/dep_pkg.sv
package dep_pkg;

   typedef enum logic [1:0] {
      RC_INT  = 2'd0,
      RC_FP   = 2'd1,
      RC_MISC = 2'd2,
      RC_NONE = 2'd3
   } reg_class_e;

endpackage

// File: rtl/dep_list.sv
module dep_list #(
   parameter int DEPTH  = 4,
   parameter int SEQ_W  = 8,
   parameter int TIME_W = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ins_en,
   input  logic [SEQ_W-1:0]              ins_seq,
   input  logic                          rm_en,
   input  logic [SEQ_W-1:0]              rm_seq,
   input  logic                          rf_en,
   input  logic [SEQ_W-1:0]              rf_seq,
   input  logic                          ex_en,
   input  logic [SEQ_W-1:0]              ex_seq,
   input  logic [TIME_W-1:0]             ex_time,
   output logic [CW-1:0]                 cnt_o,
   output logic [DEPTH-1:0][SEQ_W-1:0]   seq_o,
   output logic [DEPTH-1:0]              exe_o,
   output logic [DEPTH-1:0][TIME_W-1:0]  tim_o,
   output logic                          full_o,
   output logic                          rm_miss_o,
   output logic                          rf_bad_o
);

   if (DEPTH < 1) begin : g_chk_depth
      $error("dep_list: DEPTH must be at least 1");
   end
   if (SEQ_W < 2) begin : g_chk_seq
      $error("dep_list: SEQ_W must be at least 2");
   end

   logic [DEPTH-1:0][SEQ_W-1:0]  seq_q, s_n;
   logic [DEPTH-1:0]             exe_q, e_n;
   logic [DEPTH-1:0][TIME_W-1:0] tim_q, t_n;
   logic [CW-1:0]                cnt_q, c_n;
   logic                         hit;
   logic [CW-1:0]                pos;

   // Updates are applied in a fixed order: head removal, search removal,
   // marking, append. Every flag reflects the state at its own stage.
   always_comb begin
      s_n       = seq_q;
      e_n       = exe_q;
      t_n       = tim_q;
      c_n       = cnt_q;
      full_o    = 1'b0;
      rm_miss_o = 1'b0;
      rf_bad_o  = 1'b0;
      hit       = 1'b0;
      pos       = '0;

      if (rf_en) begin
         if (c_n != '0 && s_n[0] == rf_seq) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
               s_n[k] = s_n[k+1];
               e_n[k] = e_n[k+1];
               t_n[k] = t_n[k+1];
            end
            s_n[DEPTH-1] = '0;
            e_n[DEPTH-1] = 1'b0;
            t_n[DEPTH-1] = '0;
            c_n          = c_n - CW'(1);
         end else begin
            rf_bad_o = 1'b1;
         end
      end

      if (rm_en) begin
         for (int k = 0; k < DEPTH; k++) begin
            if (!hit && CW'(k) < c_n && s_n[k] == rm_seq) begin
               hit = 1'b1;
               pos = CW'(k);
            end
         end
         if (hit) begin
            for (int k = 0; k < DEPTH - 1; k++) begin
               if (CW'(k) >= pos) begin
                  s_n[k] = s_n[k+1];
                  e_n[k] = e_n[k+1];
                  t_n[k] = t_n[k+1];
               end
            end
            s_n[DEPTH-1] = '0;
            e_n[DEPTH-1] = 1'b0;
            t_n[DEPTH-1] = '0;
            c_n          = c_n - CW'(1);
         end else begin
            rm_miss_o = 1'b1;
         end
      end

      if (ex_en) begin
         for (int k = 0; k < DEPTH; k++) begin
            if (CW'(k) < c_n && s_n[k] == ex_seq) begin
               e_n[k] = 1'b1;
               t_n[k] = ex_time;
            end
         end
      end

      if (ins_en) begin
         if (c_n == CW'(DEPTH)) begin
            full_o = 1'b1;
         end else begin
            for (int k = 0; k < DEPTH; k++) begin
               if (CW'(k) == c_n) begin
                  s_n[k] = ins_seq;
                  e_n[k] = 1'b0;
                  t_n[k] = '0;
               end
            end
            c_n = c_n + CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= '0;
         exe_q <= '0;
         tim_q <= '0;
         cnt_q <= '0;
      end else begin
         seq_q <= s_n;
         exe_q <= e_n;
         tim_q <= t_n;
         cnt_q <= c_n;
      end
   end

   assign cnt_o = cnt_q;
   assign seq_o = seq_q;
   assign exe_o = exe_q;
   assign tim_o = tim_q;

   // R2: occupancy never exceeds the queue depth
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R2: a lone accepted append grows the queue by exactly one
   a_r2_append_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !full_o && !rf_en && !rm_en) |=> cnt_q == $past(cnt_q) + CW'(1));

   // R10: a refused append leaves the occupancy as it was
   a_r10_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !rf_en && !rm_en) |=> cnt_q == $past(cnt_q));

   // R8: a lone successful search removal shrinks the queue by one
   a_r8_remove_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (rm_en && !rm_miss_o && !rf_en && !ins_en) |=> cnt_q == $past(cnt_q) - CW'(1));

   // R9: a refused head removal leaves the head and occupancy alone
   a_r9_bad_front_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_bad_o && !rm_en && !ins_en) |=>
         (cnt_q == $past(cnt_q) && seq_q[0] == $past(seq_q[0])));

endmodule

// File: rtl/dep_query.sv
module dep_query #(
   parameter int DEPTH  = 4,
   parameter int SEQ_W  = 8,
   parameter int TIME_W = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0]                 cnt_i,
   input  logic [DEPTH-1:0][SEQ_W-1:0]   seq_i,
   input  logic [DEPTH-1:0]              exe_i,
   input  logic [DEPTH-1:0][TIME_W-1:0]  tim_i,
   input  logic [SEQ_W-1:0]              req_seq,
   input  logic [TIME_W-1:0]             now_time,
   output logic                          can_read,
   output logic                          can_write,
   output logic                          fwd_hit,
   output logic [SEQ_W-1:0]              fwd_seq
);

   logic              cand, stop, c_exe;
   logic [SEQ_W-1:0]  c_seq;
   logic [TIME_W-1:0] c_tim;

   always_comb begin
      can_read  = (cnt_i == '0) || (req_seq <= seq_i[0]);
      can_write = (cnt_i == '0) || !(req_seq > seq_i[0]);

      cand  = 1'b0;
      stop  = 1'b0;
      c_exe = 1'b0;
      c_seq = '0;
      c_tim = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (!stop && CW'(k) < cnt_i && seq_i[k] < req_seq) begin
            cand  = 1'b1;
            c_exe = exe_i[k];
            c_seq = seq_i[k];
            c_tim = tim_i[k];
         end else begin
            stop = 1'b1;
         end
      end

      fwd_hit = cand && c_exe && (c_tim < now_time);
      fwd_seq = fwd_hit ? c_seq : '0;
   end

endmodule

// File: rtl/dep_scoreboard.sv
module dep_scoreboard
   import dep_pkg::*;
#(
   parameter int NUM_INT  = 8,
   parameter int NUM_FP   = 8,
   parameter int NUM_MISC = 4,
   parameter int IDX_W    = 3,
   parameter int DEPTH    = 4,
   parameter int SEQ_W    = 8,
   parameter int TIME_W   = 16,
   parameter bit HAS_ZERO = 1'b1,
   parameter int ZERO_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [1:0]        ins_class,
   input  logic [IDX_W-1:0]  ins_idx,
   input  logic [SEQ_W-1:0]  ins_seq,
   output logic              ins_full_o,
   input  logic              rm_valid,
   input  logic [1:0]        rm_class,
   input  logic [IDX_W-1:0]  rm_idx,
   input  logic [SEQ_W-1:0]  rm_seq,
   output logic              rm_miss_o,
   input  logic              rf_valid,
   input  logic [1:0]        rf_class,
   input  logic [IDX_W-1:0]  rf_idx,
   input  logic [SEQ_W-1:0]  rf_seq,
   output logic              rf_bad_o,
   input  logic              ex_valid,
   input  logic [1:0]        ex_class,
   input  logic [IDX_W-1:0]  ex_idx,
   input  logic [SEQ_W-1:0]  ex_seq,
   input  logic [TIME_W-1:0] ex_time,
   input  logic [TIME_W-1:0] now_time,
   input  logic [1:0]        q_class,
   input  logic [IDX_W-1:0]  q_idx,
   input  logic [SEQ_W-1:0]  q_seq,
   output logic              q_can_read,
   output logic              q_can_write,
   output logic              q_fwd_hit,
   output logic [SEQ_W-1:0]  q_fwd_seq
);

   localparam int TOT = NUM_INT + NUM_FP + NUM_MISC;
   localparam int GW  = $clog2(TOT);
   localparam int CW  = $clog2(DEPTH + 1);

   if (NUM_INT < 1 || NUM_FP < 1 || NUM_MISC < 1) begin : g_chk_cls
      $error("dep_scoreboard: every class needs at least one register");
   end
   if (TOT < 2) begin : g_chk_tot
      $error("dep_scoreboard: at least two registers are required");
   end
   if (NUM_INT > (1 << IDX_W) || NUM_FP > (1 << IDX_W) || NUM_MISC > (1 << IDX_W)) begin : g_chk_idx
      $error("dep_scoreboard: IDX_W too narrow for the class sizes");
   end
   if (HAS_ZERO && (ZERO_IDX < 0 || ZERO_IDX >= NUM_INT)) begin : g_chk_zero
      $error("dep_scoreboard: ZERO_IDX outside the integer class");
   end

   // Returns {valid, flat index}; class 3 and out-of-range indices are invalid.
   function automatic logic [GW:0] map_reg(input logic [1:0] c, input logic [IDX_W-1:0] i);
      logic v;
      int   gi;
      v  = 1'b0;
      gi = 0;
      case (c)
         RC_INT:  begin v = (int'(i) < NUM_INT);  gi = int'(i); end
         RC_FP:   begin v = (int'(i) < NUM_FP);   gi = NUM_INT + int'(i); end
         RC_MISC: begin v = (int'(i) < NUM_MISC); gi = NUM_INT + NUM_FP + int'(i); end
         default: begin v = 1'b0; gi = 0; end
      endcase
      return {v, GW'(gi)};
   endfunction

   function automatic logic is_zero(input logic [1:0] c, input logic [IDX_W-1:0] i);
      return (c == RC_INT) && (i == IDX_W'(ZERO_IDX));
   endfunction

   logic [GW:0] ins_m, rm_m, rf_m, ex_m, q_m;
   logic        zero_ins, zero_rm, zero_rf, zero_ex;

   assign ins_m = map_reg(ins_class, ins_idx);
   assign rm_m  = map_reg(rm_class, rm_idx);
   assign rf_m  = map_reg(rf_class, rf_idx);
   assign ex_m  = map_reg(ex_class, ex_idx);
   assign q_m   = map_reg(q_class, q_idx);

   if (HAS_ZERO) begin : g_zero
      assign zero_ins = is_zero(ins_class, ins_idx);
      assign zero_rm  = is_zero(rm_class, rm_idx);
      assign zero_rf  = is_zero(rf_class, rf_idx);
      assign zero_ex  = is_zero(ex_class, ex_idx);

      // R3: an append to the zero register is never refused as full
      a_r3_zero_never_full: assert property (@(posedge clk) disable iff (!rst_n)
         (ins_valid && zero_ins) |-> !ins_full_o);
   end else begin : g_nozero
      assign zero_ins = 1'b0;
      assign zero_rm  = 1'b0;
      assign zero_rf  = 1'b0;
      assign zero_ex  = 1'b0;
   end

   logic [CW-1:0]                cnt_all [TOT];
   logic [DEPTH-1:0][SEQ_W-1:0]  seq_all [TOT];
   logic [DEPTH-1:0]             exe_all [TOT];
   logic [DEPTH-1:0][TIME_W-1:0] tim_all [TOT];
   logic [TOT-1:0]               full_v, miss_v, bad_v;

   for (genvar g = 0; g < TOT; g++) begin : g_list
      logic ins_en_g, rm_en_g, rf_en_g, ex_en_g;
      assign ins_en_g = ins_valid && ins_m[GW] && !zero_ins && (ins_m[GW-1:0] == GW'(g));
      assign rm_en_g  = rm_valid  && rm_m[GW]  && !zero_rm  && (rm_m[GW-1:0]  == GW'(g));
      assign rf_en_g  = rf_valid  && rf_m[GW]  && !zero_rf  && (rf_m[GW-1:0]  == GW'(g));
      assign ex_en_g  = ex_valid  && ex_m[GW]  && !zero_ex  && (ex_m[GW-1:0]  == GW'(g));

      dep_list #(
         .DEPTH  (DEPTH),
         .SEQ_W  (SEQ_W),
         .TIME_W (TIME_W)
      ) u_list (
         .clk       (clk),
         .rst_n     (rst_n),
         .ins_en    (ins_en_g),
         .ins_seq   (ins_seq),
         .rm_en     (rm_en_g),
         .rm_seq    (rm_seq),
         .rf_en     (rf_en_g),
         .rf_seq    (rf_seq),
         .ex_en     (ex_en_g),
         .ex_seq    (ex_seq),
         .ex_time   (ex_time),
         .cnt_o     (cnt_all[g]),
         .seq_o     (seq_all[g]),
         .exe_o     (exe_all[g]),
         .tim_o     (tim_all[g]),
         .full_o    (full_v[g]),
         .rm_miss_o (miss_v[g]),
         .rf_bad_o  (bad_v[g])
      );
   end

   assign ins_full_o = |full_v;
   assign rm_miss_o  = |miss_v;
   assign rf_bad_o   = |bad_v;

   // Query side: select one queue, then evaluate it once.
   logic [CW-1:0]                sel_cnt;
   logic [DEPTH-1:0][SEQ_W-1:0]  sel_seq;
   logic [DEPTH-1:0]             sel_exe;
   logic [DEPTH-1:0][TIME_W-1:0] sel_tim;

   always_comb begin
      sel_cnt = '0;
      sel_seq = '0;
      sel_exe = '0;
      sel_tim = '0;
      for (int g = 0; g < TOT; g++) begin
         if (q_m[GW] && q_m[GW-1:0] == GW'(g)) begin
            sel_cnt = cnt_all[g];
            sel_seq = seq_all[g];
            sel_exe = exe_all[g];
            sel_tim = tim_all[g];
         end
      end
   end

   dep_query #(
      .DEPTH  (DEPTH),
      .SEQ_W  (SEQ_W),
      .TIME_W (TIME_W)
   ) u_query (
      .cnt_i     (sel_cnt),
      .seq_i     (sel_seq),
      .exe_i     (sel_exe),
      .tim_i     (sel_tim),
      .req_seq   (q_seq),
      .now_time  (now_time),
      .can_read  (q_can_read),
      .can_write (q_can_write),
      .fwd_hit   (q_fwd_hit),
      .fwd_seq   (q_fwd_seq)
   );

   // R6: a forwarding source is always strictly older than the requester
   a_r6_fwd_older: assert property (@(posedge clk) disable iff (!rst_n)
      q_fwd_hit |-> (q_fwd_seq < q_seq));

   // R4: an older producer in the queue means the register file is stale
   a_r4_fwd_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
      q_fwd_hit |-> (!q_can_read && !q_can_write));

   // R1: the unused class code names no register
   a_r1_no_class: assert property (@(posedge clk) disable iff (!rst_n)
      (q_class == RC_NONE) |-> (q_can_read && !q_fwd_hit));

endmodule

// File: tb/test_dep_scoreboard.sv
module test_dep_scoreboard;

   localparam int IDX_W  = 3;
   localparam int SEQ_W  = 8;
   localparam int TIME_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ins_valid = 1'b0, rm_valid = 1'b0, rf_valid = 1'b0, ex_valid = 1'b0;
   logic [1:0]        ins_class = '0, rm_class = '0, rf_class = '0, ex_class = '0, q_class = '0;
   logic [IDX_W-1:0]  ins_idx = '0, rm_idx = '0, rf_idx = '0, ex_idx = '0, q_idx = '0;
   logic [SEQ_W-1:0]  ins_seq = '0, rm_seq = '0, rf_seq = '0, ex_seq = '0, q_seq = '0;
   logic [TIME_W-1:0] ex_time = '0, now_time = '0;
   logic              ins_full_o, rm_miss_o, rf_bad_o;
   logic              q_can_read, q_can_write, q_fwd_hit;
   logic [SEQ_W-1:0]  q_fwd_seq;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   dep_scoreboard i_dep_scoreboard (
      .clk, .rst_n,
      .ins_valid, .ins_class, .ins_idx, .ins_seq, .ins_full_o,
      .rm_valid, .rm_class, .rm_idx, .rm_seq, .rm_miss_o,
      .rf_valid, .rf_class, .rf_idx, .rf_seq, .rf_bad_o,
      .ex_valid, .ex_class, .ex_idx, .ex_seq, .ex_time,
      .now_time,
      .q_class, .q_idx, .q_seq, .q_can_read, .q_can_write, .q_fwd_hit, .q_fwd_seq
   );

   // kind: 0 append, 1 search removal, 2 head removal, 3 mark, 4 query
   typedef struct packed {
      logic [2:0]  kind;
      logic [1:0]  cls;
      logic [2:0]  idx;
      logic [7:0]  seq;
      logic [15:0] tm;
      logic        er;
      logic        rd;
      logic        wr;
      logic        fh;
      logic [7:0]  fs;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t VT [NV] = '{
      '{3'd4, 2'd0, 3'd5,  8'd10, 16'd0,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd12}, // R12 empty after reset
      '{3'd0, 2'd0, 3'd5,  8'd10, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd2},
      '{3'd0, 2'd0, 3'd5,  8'd20, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd2},
      '{3'd0, 2'd0, 3'd5,  8'd30, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd2},
      '{3'd4, 2'd0, 3'd5,  8'd10, 16'd0,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd4},  // R4 equal to head
      '{3'd4, 2'd0, 3'd5,  8'd11, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd5},  // R5 younger than head
      '{3'd3, 2'd0, 3'd5,  8'd10, 16'd5,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd11},
      '{3'd4, 2'd0, 3'd5,  8'd25, 16'd5,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd6},  // R6 picks 20, not executed
      '{3'd4, 2'd0, 3'd5,  8'd15, 16'd5,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd7},  // R7 stamp equals now
      '{3'd4, 2'd0, 3'd5,  8'd15, 16'd6,   1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 8'd7},  // R7 stamp passed
      '{3'd3, 2'd0, 3'd5,  8'd20, 16'd7,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd11},
      '{3'd4, 2'd0, 3'd5,  8'd25, 16'd9,   1'b0, 1'b0, 1'b0, 1'b1, 8'd20, 8'd6},  // R6 youngest older
      '{3'd4, 2'd1, 3'd5,  8'd25, 16'd9,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd1},  // R1 other class
      '{3'd0, 2'd0, 3'd5,  8'd40, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd2},
      '{3'd0, 2'd0, 3'd5,  8'd50, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd10}, // R10 full
      '{3'd1, 2'd0, 3'd5,  8'd50, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd10}, // R10 50 absent
      '{3'd1, 2'd0, 3'd5,  8'd20, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd8},  // R8 middle delete
      '{3'd4, 2'd0, 3'd5,  8'd25, 16'd100, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 8'd8},  // R8 compacted
      '{3'd1, 2'd0, 3'd5,  8'd77, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd8},  // R8 missing
      '{3'd2, 2'd0, 3'd5,  8'd30, 16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd9},  // R9 mismatch
      '{3'd2, 2'd0, 3'd5,  8'd10, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd9},
      '{3'd4, 2'd0, 3'd5,  8'd30, 16'd100, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd9},  // R9 new head 30
      '{3'd4, 2'd0, 3'd5,  8'd31, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd9},
      '{3'd0, 2'd0, 3'd0,  8'd5,  16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd3},  // R3 zero append
      '{3'd4, 2'd0, 3'd0,  8'd9,  16'd0,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd3},
      '{3'd1, 2'd0, 3'd0,  8'd5,  16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd3},
      '{3'd2, 2'd0, 3'd0,  8'd5,  16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd3},
      '{3'd0, 2'd1, 3'd0,  8'd5,  16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd1},
      '{3'd4, 2'd1, 3'd0,  8'd9,  16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd1},  // R1 fp 0 tracked
      '{3'd0, 2'd2, 3'd3,  8'd60, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd11},
      '{3'd3, 2'd2, 3'd3,  8'd60, 16'd2,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd11},
      '{3'd4, 2'd2, 3'd3,  8'd61, 16'd3,   1'b0, 1'b0, 1'b0, 1'b1, 8'd60, 8'd11}, // R11 marked
      '{3'd4, 2'd2, 3'd3,  8'd61, 16'd2,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd7},
      '{3'd2, 2'd1, 3'd0,  8'd5,  16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd9},
      '{3'd4, 2'd1, 3'd0,  8'd9,  16'd0,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd9},
      '{3'd2, 2'd1, 3'd0,  8'd5,  16'd0,   1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  8'd9},  // R9 empty
      '{3'd1, 2'd0, 3'd5,  8'd30, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd8},
      '{3'd1, 2'd0, 3'd5,  8'd40, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  8'd8},
      '{3'd4, 2'd0, 3'd5,  8'd99, 16'd0,   1'b0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd8}
   };

   task automatic check(input int rq, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic idle();
      ins_valid = 1'b0;
      rm_valid  = 1'b0;
      rf_valid  = 1'b0;
      ex_valid  = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      idle();
      case (v.kind)
         3'd0: begin ins_valid = 1'b1; ins_class = v.cls; ins_idx = v.idx; ins_seq = v.seq; end
         3'd1: begin rm_valid = 1'b1; rm_class = v.cls; rm_idx = v.idx; rm_seq = v.seq; end
         3'd2: begin rf_valid = 1'b1; rf_class = v.cls; rf_idx = v.idx; rf_seq = v.seq; end
         3'd3: begin ex_valid = 1'b1; ex_class = v.cls; ex_idx = v.idx; ex_seq = v.seq; ex_time = v.tm; end
         default: begin q_class = v.cls; q_idx = v.idx; q_seq = v.seq; now_time = v.tm; end
      endcase
      #5;
      case (v.kind)
         3'd0: check(int'(v.rq), "append full flag", int'(ins_full_o), int'(v.er));
         3'd1: check(int'(v.rq), "search miss flag", int'(rm_miss_o), int'(v.er));
         3'd2: check(int'(v.rq), "head removal flag", int'(rf_bad_o), int'(v.er));
         3'd3: ;
         default: begin
            check(int'(v.rq), "can_read", int'(q_can_read), int'(v.rd));
            check(int'(v.rq), "can_write", int'(q_can_write), int'(v.wr));
            check(int'(v.rq), "fwd_hit", int'(q_fwd_hit), int'(v.fh));
            check(int'(v.rq), "fwd_seq", int'(q_fwd_seq), int'(v.fs));
         end
      endcase
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int n = 0; n < NV; n++) run_vec(VT[n]);

      // R1: class code 3 and an out-of-range misc index name no register
      run_vec('{3'd0, 2'd3, 3'd1, 8'd7, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd1});
      run_vec('{3'd4, 2'd3, 3'd1, 8'd9, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd1});
      run_vec('{3'd4, 2'd2, 3'd6, 8'd9, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd1});

      // R12: reset in the middle of a run empties every queue
      run_vec('{3'd0, 2'd0, 3'd2, 8'd1, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd12});
      run_vec('{3'd0, 2'd1, 3'd7, 8'd2, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd12});
      run_vec('{3'd4, 2'd0, 3'd2, 8'd5, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd12});
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      run_vec('{3'd4, 2'd0, 3'd2, 8'd5, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd12});
      run_vec('{3'd4, 2'd1, 3'd7, 8'd5, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd12});
      run_vec('{3'd2, 2'd0, 3'd2, 8'd1, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd12});

      @(negedge clk);
      idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule